// File: doc/BRIEF.md
# Byte-Port Packet Device Register Block

This block is a memory-mapped slave that sits between a host bus and a simple packet device. The host finds the device through a fixed identification word, watches a busy flag, and moves frames one byte per register access. A count register counts down as bytes move through a single-byte port. On the device side, received frames arrive as a byte stream with a last-byte marker and are held in an internal buffer. Transmit bytes written by the host leave on an output byte stream, with the final byte of the declared length marked as last.

A single interrupt line reports three sources: a finished transmit, a received frame that is waiting, and a test interrupt that software raises on purpose. A waiting received frame holds off the next frame until software acknowledges it. The visible test bit reads as set exactly once. The test interrupt line stays up until software writes zero to the interrupt control register.

Host accesses complete in one cycle. Read data is combinational from the current address. Read and write side effects take place at the clock edge that ends the access.

Top module: `pktRegPort`

## Requirements
- R1: The word at offset 0x00 reads 0x45545942 and the word at 0x04 reads 0x3154454E. Taken byte by byte from the least significant byte up, the eight bytes spell "BYTENET" followed by the ASCII version digit (default 1). The word at 0x18 reads the INFO_WORD parameter (default 0).
- R2: Bit 0 of offset 0x08 reads 1 in two cases: while a receive frame is partly collected, or while the transmit count is nonzero. It reads 0 otherwise.
- R3: When a frame completes, offset 0x0C holds its stored byte count. Each read of offset 0x1C returns the next stored byte in bits 7:0, with zeros above, and lowers the count by one. A read of 0x1C when the count is zero returns 0 and leaves the count at zero.
- R4: A write to offset 0x10 loads bits 16:0 as the transmit count, and reads of 0x10 return the remaining count. Each write to 0x20 while the count is nonzero does three things: it drives bits 7:0 on txData with txValid high for the following cycle, it drives txLast high with the final byte, and it lowers the count by one. Writes to 0x20 while the count is zero produce no txValid.
- R5: Interrupt control bit 0 (offset 0x14) sets in the same edge that the final transmit byte is emitted. Writing 1 to bit 0 clears it.
- R6: Interrupt control bit 1 sets when a frame's last byte is taken. Writing 1 to bit 1 clears it. While bit 1 is set, rxReady is low, stream bytes are not taken, and the held frame's count and bytes are unchanged.
- R7: Writing a value with bit 31 set raises the test interrupt, and bit 31 reads 1. The first read of 0x14 after that returns bit 31 as 1, and later reads return 0 while irq stays high. Writing 0 to 0x14 drops the test interrupt.
- R8: irq is high exactly when the transmit-done bit, the receive-done bit or the test interrupt is active. After reset irq is low and rxReady is high.
- R9: A frame longer than BUF_DEPTH bytes keeps its first BUF_DEPTH bytes, and its count reads BUF_DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 6 | Byte address of the register accessed |
| busWrEn | input | 1 | Write strobe, one cycle per access |
| busRdEn | input | 1 | Read strobe, one cycle per access |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data for the current address |
| irq | output | 1 | Interrupt request |
| rxValid | input | 1 | Received byte present on rxData |
| rxData | input | 8 | Received byte |
| rxLast | input | 1 | Marks the final byte of a received frame |
| rxReady | output | 1 | High when stream bytes are taken |
| txValid | output | 1 | Transmit byte present on txData |
| txData | output | 8 | Transmit byte |
| txLast | output | 1 | Marks the final byte of a transmit frame |

## Verification
The bench builds the block with BUF_DEPTH set to 8. At that depth the truncation of an over-long frame is reached with a ten-byte frame, and a frame of a few bytes already exercises read-order sequencing. The count width keeps its default of 17 bits, so the full 65536 length can be loaded and read back. The version digit and info word stay at their defaults, and the identification and info reads are checked against those fixed words.

// File: rtl/pktRegPkg.sv
package pktRegPkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_ID_LO  = 6'h00;
  localparam logic [ADDR_W-1:0] A_ID_HI  = 6'h04;
  localparam logic [ADDR_W-1:0] A_BUSY   = 6'h08;
  localparam logic [ADDR_W-1:0] A_RXCNT  = 6'h0C;
  localparam logic [ADDR_W-1:0] A_TXCNT  = 6'h10;
  localparam logic [ADDR_W-1:0] A_INTCTL = 6'h14;
  localparam logic [ADDR_W-1:0] A_INFO   = 6'h18;
  localparam logic [ADDR_W-1:0] A_RXDATA = 6'h1C;
  localparam logic [ADDR_W-1:0] A_TXDATA = 6'h20;

  // strobes from the control decoder to the datapath
  typedef struct packed {
    logic rxPop;   // host read of receive data port
    logic txLoad;  // host write of transmit count
    logic txPush;  // host write of transmit data port
  } hostStrb_t;
endpackage

// File: rtl/pktRegCtrl.sv
module pktRegCtrl
  import pktRegPkg::*;
#(
  parameter int          CNT_W     = 17,
  parameter int          ID_DIGIT  = 1,
  parameter logic [31:0] INFO_WORD = 32'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [31:0]       busWData,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [CNT_W-1:0]  txRemain,
  input  logic [7:0]        rxByte,
  input  logic              busyFlag,
  input  logic              txDoneEv,
  input  logic              rxDoneEv,
  output hostStrb_t         strb,
  output logic [31:0]       busRData,
  output logic              irq,
  output logic              rxBlocked
);
  localparam logic [7:0]  VER_CH = 8'(48 + ID_DIGIT);
  localparam logic [31:0] ID_LO  = "ETYB";
  localparam logic [31:0] ID_HI  = {VER_CH, "TEN"};

  logic txDoneF, rxDoneF, testVis, testIrq;
  logic intWr, intRd;

  assign intWr = busWrEn && (busAddr == A_INTCTL);
  assign intRd = busRdEn && (busAddr == A_INTCTL);

  always_comb begin
    strb.rxPop  = busRdEn && (busAddr == A_RXDATA);
    strb.txLoad = busWrEn && (busAddr == A_TXCNT);
    strb.txPush = busWrEn && (busAddr == A_TXDATA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txDoneF <= 1'b0;
      rxDoneF <= 1'b0;
      testVis <= 1'b0;
      testIrq <= 1'b0;
    end else begin
      txDoneF <= (txDoneF && !(intWr && busWData[0])) || txDoneEv;
      rxDoneF <= (rxDoneF && !(intWr && busWData[1])) || rxDoneEv;
      if (intWr && busWData[31]) begin
        testVis <= 1'b1;
        testIrq <= 1'b1;
      end else if (intWr && (busWData == 32'h0)) begin
        testVis <= 1'b0;
        testIrq <= 1'b0;
      end else if (intRd) begin
        testVis <= 1'b0;
      end
    end
  end

  assign irq       = txDoneF || rxDoneF || testIrq;
  assign rxBlocked = rxDoneF;

  always_comb begin
    case (busAddr)
      A_ID_LO:  busRData = ID_LO;
      A_ID_HI:  busRData = ID_HI;
      A_BUSY:   busRData = {31'b0, busyFlag};
      A_RXCNT:  busRData = 32'(rxCount);
      A_TXCNT:  busRData = 32'(txRemain);
      A_INTCTL: busRData = {testVis, 29'b0, rxDoneF, txDoneF};
      A_INFO:   busRData = INFO_WORD;
      A_RXDATA: busRData = (rxCount != '0) ? {24'b0, rxByte} : 32'h0;
      default:  busRData = 32'h0;
    endcase
  end
endmodule

// File: rtl/pktRegData.sv
module pktRegData
  import pktRegPkg::*;
#(
  parameter int BUF_DEPTH = 64,
  parameter int CNT_W     = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  hostStrb_t        strb,
  input  logic [CNT_W-1:0] txWord,
  input  logic [7:0]       txWByte,
  input  logic             rxValid,
  input  logic [7:0]       rxData,
  input  logic             rxLast,
  input  logic             rxBlocked,
  output logic [CNT_W-1:0] rxCount,
  output logic [CNT_W-1:0] txRemain,
  output logic [7:0]       rxByte,
  output logic             busyFlag,
  output logic             txDoneEv,
  output logic             rxDoneEv,
  output logic             txValid,
  output logic [7:0]       txData,
  output logic             txLast
);
  localparam int IDX_W  = $clog2(BUF_DEPTH);
  localparam int FILL_W = $clog2(BUF_DEPTH + 1);

  logic [7:0]        mem [BUF_DEPTH];
  logic [FILL_W-1:0] collCnt, frameLen, newLen;
  logic              collecting, rxTake, room;
  logic [IDX_W-1:0]  rdIdx;

  assign rxTake   = rxValid && !rxBlocked;
  assign room     = collCnt < FILL_W'(BUF_DEPTH);
  assign newLen   = room ? collCnt + FILL_W'(1) : collCnt;
  assign rxDoneEv = rxTake && rxLast;
  assign rdIdx    = IDX_W'(CNT_W'(frameLen) - rxCount);
  assign rxByte   = mem[rdIdx];

  always_ff @(posedge clk) begin
    if (rxTake && room) mem[collCnt[IDX_W-1:0]] <= rxData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      collCnt    <= '0;
      frameLen   <= '0;
      collecting <= 1'b0;
      rxCount    <= '0;
    end else begin
      if (strb.rxPop && (rxCount != '0)) rxCount <= rxCount - CNT_W'(1);
      if (rxTake) begin
        if (rxLast) begin
          frameLen   <= newLen;
          rxCount    <= CNT_W'(newLen);
          collCnt    <= '0;
          collecting <= 1'b0;
        end else begin
          collCnt    <= newLen;
          collecting <= 1'b1;
        end
      end
    end
  end

  assign txDoneEv = strb.txPush && (txRemain == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txRemain <= '0;
      txValid  <= 1'b0;
      txLast   <= 1'b0;
      txData   <= 8'h0;
    end else begin
      txValid <= 1'b0;
      txLast  <= 1'b0;
      if (strb.txLoad) begin
        txRemain <= txWord;
      end else if (strb.txPush && (txRemain != '0)) begin
        txValid  <= 1'b1;
        txLast   <= (txRemain == CNT_W'(1));
        txData   <= txWByte;
        txRemain <= txRemain - CNT_W'(1);
      end
    end
  end

  assign busyFlag = collecting || (txRemain != '0);
endmodule

// File: rtl/pktRegPort.sv
module pktRegPort
  import pktRegPkg::*;
#(
  parameter int          BUF_DEPTH = 64,
  parameter int          CNT_W     = 17,
  parameter int          ID_DIGIT  = 1,
  parameter logic [31:0] INFO_WORD = 32'h0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  busAddr,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [31:0] busWData,
  output logic [31:0] busRData,
  output logic        irq,
  input  logic        rxValid,
  input  logic [7:0]  rxData,
  input  logic        rxLast,
  output logic        rxReady,
  output logic        txValid,
  output logic [7:0]  txData,
  output logic        txLast
);
  hostStrb_t        strb;
  logic [CNT_W-1:0] rxCount, txRemain;
  logic [7:0]       rxByte;
  logic             busyFlag, txDoneEv, rxDoneEv, rxBlocked;

  pktRegCtrl #(.CNT_W(CNT_W), .ID_DIGIT(ID_DIGIT), .INFO_WORD(INFO_WORD)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWData(busWData), .rxCount(rxCount),
    .txRemain(txRemain), .rxByte(rxByte), .busyFlag(busyFlag),
    .txDoneEv(txDoneEv), .rxDoneEv(rxDoneEv), .strb(strb),
    .busRData(busRData), .irq(irq), .rxBlocked(rxBlocked)
  );

  pktRegData #(.BUF_DEPTH(BUF_DEPTH), .CNT_W(CNT_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .txWord(busWData[CNT_W-1:0]),
    .txWByte(busWData[7:0]), .rxValid(rxValid), .rxData(rxData),
    .rxLast(rxLast), .rxBlocked(rxBlocked), .rxCount(rxCount),
    .txRemain(txRemain), .rxByte(rxByte), .busyFlag(busyFlag),
    .txDoneEv(txDoneEv), .rxDoneEv(rxDoneEv), .txValid(txValid),
    .txData(txData), .txLast(txLast)
  );

  assign rxReady = !rxBlocked;
endmodule

// File: rtl/pktRegPortChk.sv
module pktRegPortChk
  import pktRegPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [5:0] busAddr,
  input logic       busWrEn,
  input logic       irq,
  input logic       rxReady,
  input logic       txValid,
  input logic       txLast,
  input logic       busyFlag
);
  // final transmit byte and the done interrupt appear together (R5)
  p_txlast_irq_r5: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txLast) |-> irq);

  // a held frame keeps the interrupt line up (R6)
  p_rxblock_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
    !rxReady |-> irq);

  // output bytes only follow a data-port write (R4)
  p_txvalid_src_r4: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(busWrEn && (busAddr == A_TXDATA)));

  // a non-final byte leaves the transmit outstanding (R2)
  p_busy_tx_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txLast) |-> busyFlag);
endmodule

bind pktRegPort pktRegPortChk u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .irq(irq), .rxReady(rxReady), .txValid(txValid), .txLast(txLast),
  .busyFlag(busyFlag)
);

// File: tb/pktRegPort_test.sv
module pktRegPort_test;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic        irq, rxReady, txValid, txLast;
  logic [7:0]  txData;
  logic        rxValid = 1'b0, rxLast = 1'b0;
  logic [7:0]  rxData = '0;

  int vecs = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pktRegPort #(.BUF_DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWData(busWData), .busRData(busRData), .irq(irq),
    .rxValid(rxValid), .rxData(rxData), .rxLast(rxLast), .rxReady(rxReady),
    .txValid(txValid), .txData(txData), .txLast(txLast)
  );

  // behavioural reference state
  int         mTxRem = 0, mRxCnt = 0;
  bit         mTxV = 0, mTxL = 0, mTxDone = 0, mRxDone = 0;
  bit         mTestVis = 0, mTestIrq = 0, mColl = 0;
  logic [7:0] mTxD = 0;
  logic [7:0] coll[$];
  logic [7:0] held[$];

  task automatic chk(string req, string what, longint act, longint exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mdlRead(logic [5:0] a);
    case (a)
      6'h00: return 32'h45545942;
      6'h04: return 32'h3154454E;
      6'h08: return {31'b0, (mColl || mTxRem != 0)};
      6'h0C: return mRxCnt;
      6'h10: return mTxRem;
      6'h14: return {mTestVis, 29'b0, mRxDone, mTxDone};
      6'h1C: return (mRxCnt != 0) ? {24'b0, held[held.size() - mRxCnt]} : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string reqOf(logic [5:0] a);
    case (a)
      6'h00, 6'h04, 6'h18: return "R1";
      6'h08: return "R2";
      6'h0C, 6'h1C: return "R3";
      6'h10: return "R4";
      6'h14: return "R7";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mTxRem = 0; mRxCnt = 0; mTxV = 0; mTxL = 0; mTxDone = 0; mRxDone = 0;
      mTestVis = 0; mTestIrq = 0; mColl = 0; coll.delete(); held.delete();
    end else begin
      bit take, intWr, txSet, rxSet;
      take  = rxValid && !mRxDone;
      intWr = busWrEn && busAddr == 6'h14;
      txSet = 0; rxSet = 0;
      mTxV = 0; mTxL = 0;
      if (busWrEn && busAddr == 6'h10) mTxRem = busWData & 32'h1FFFF;
      else if (busWrEn && busAddr == 6'h20 && mTxRem != 0) begin
        mTxV = 1; mTxD = busWData[7:0]; mTxL = (mTxRem == 1);
        txSet = (mTxRem == 1); mTxRem--;
      end
      if (busRdEn && busAddr == 6'h1C && mRxCnt != 0) mRxCnt--;
      if (take) begin
        if (coll.size() < DEPTH) coll.push_back(rxData);
        if (rxLast) begin
          held = coll; mRxCnt = coll.size(); coll.delete(); mColl = 0; rxSet = 1;
        end else mColl = 1;
      end
      if (intWr && busWData[31]) begin mTestVis = 1; mTestIrq = 1; end
      else if (intWr && busWData == 0) begin mTestVis = 0; mTestIrq = 0; end
      else if (busRdEn && busAddr == 6'h14) mTestVis = 0;
      mTxDone = (mTxDone && !(intWr && busWData[0])) || txSet;
      mRxDone = (mRxDone && !(intWr && busWData[1])) || rxSet;
    end
  end

  // compare with the reference on every clock
  always @(negedge clk) begin
    #1;
    if (rstN && !done) begin
      chk("R8", "irq", irq, mTxDone || mRxDone || mTestIrq);
      chk("R6", "rxReady", rxReady, !mRxDone);
      chk("R4", "txValid", txValid, mTxV);
      if (mTxV) begin
        chk("R4", "txData", txData, mTxD);
        chk("R4", "txLast", txLast, mTxL);
      end
      if (busRdEn) chk(reqOf(busAddr), "busRData", busRData, mdlRead(busAddr));
    end
  end

  task automatic step(logic [5:0] a, bit w, bit r, logic [31:0] d,
                      bit rv, logic [7:0] rb, bit rl);
    @(negedge clk);
    busAddr = a; busWrEn = w; busRdEn = r; busWData = d;
    rxValid = rv; rxData = rb; rxLast = rl;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(6'h0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    step(a, 1, 0, d, 0, 0, 0);
  endtask

  task automatic rdExp(logic [5:0] a, logic [31:0] exp, string req);
    step(a, 0, 1, 0, 0, 0, 0);
    #1 chk(req, "read", busRData, exp);
  endtask

  task automatic rxByte(logic [7:0] b, bit last);
    step(6'h0, 0, 0, 0, 1, b, last);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    #1;
    chk("R8", "irq after reset", irq, 0);
    chk("R8", "rxReady after reset", rxReady, 1);
    rdExp(6'h00, 32'h45545942, "R1");
    rdExp(6'h04, 32'h3154454E, "R1");
    rdExp(6'h18, 32'h0, "R1");
    rdExp(6'h08, 32'h0, "R2");
    rdExp(6'h14, 32'h0, "R5");

    // transmit of three bytes, upper data bits ignored
    wr(6'h10, 32'h3);
    rdExp(6'h08, 32'h1, "R2");
    rdExp(6'h10, 32'h3, "R4");
    wr(6'h20, 32'h1A1);
    wr(6'h20, 32'h2B);
    wr(6'h20, 32'h3C);
    idle(1);
    #1 chk("R5", "irq after last tx byte", irq, 1);
    rdExp(6'h10, 32'h0, "R4");
    rdExp(6'h14, 32'h1, "R5");
    wr(6'h20, 32'h55);
    idle(1);
    #1 chk("R4", "txValid for surplus write", txValid, 0);
    wr(6'h14, 32'h1);
    idle(1);
    #1 chk("R5", "irq after tx ack", irq, 0);
    rdExp(6'h08, 32'h0, "R2");

    // receive a four byte frame
    rxByte(8'h11, 0);
    step(6'h08, 0, 1, 0, 1, 8'h22, 0);
    #1 chk("R2", "busy mid frame", busRData, 1);
    rxByte(8'h33, 0);
    rxByte(8'h44, 1);
    idle(1);
    #1 chk("R6", "rxReady held", rxReady, 0);
    rdExp(6'h0C, 32'h4, "R3");
    rdExp(6'h14, 32'h2, "R6");
    rxByte(8'h99, 1);
    idle(1);
    rdExp(6'h0C, 32'h4, "R6");
    rdExp(6'h1C, 32'h11, "R6");
    rdExp(6'h1C, 32'h22, "R3");
    rdExp(6'h1C, 32'h33, "R3");
    rdExp(6'h1C, 32'h44, "R3");
    rdExp(6'h1C, 32'h0, "R3");
    rdExp(6'h0C, 32'h0, "R3");
    wr(6'h14, 32'h2);
    idle(1);
    #1 chk("R6", "rxReady after ack", rxReady, 1);

    // over-long frame keeps the first DEPTH bytes
    for (int i = 0; i < 10; i++) rxByte(8'(i + 8'h40), i == 9);
    idle(1);
    rdExp(6'h0C, DEPTH, "R9");
    for (int i = 0; i < DEPTH; i++) rdExp(6'h1C, 32'(i + 8'h40), "R9");
    wr(6'h14, 32'h2);

    // test interrupt
    wr(6'h14, 32'h8000_0000);
    idle(1);
    #1 chk("R7", "irq on test", irq, 1);
    rdExp(6'h14, 32'h8000_0000, "R7");
    rdExp(6'h14, 32'h0, "R7");
    #1 chk("R7", "irq held after read", irq, 1);
    wr(6'h14, 32'h0);
    idle(1);
    #1 chk("R7", "irq after zero write", irq, 0);

    // two sources at once
    wr(6'h10, 32'h1);
    wr(6'h20, 32'hA5);
    wr(6'h14, 32'h8000_0000);
    wr(6'h14, 32'h1);
    idle(1);
    #1 chk("R8", "irq with test still up", irq, 1);
    wr(6'h14, 32'h0);
    idle(1);
    #1 chk("R8", "irq all clear", irq, 0);

    // largest count
    wr(6'h10, 32'h1_0000);
    rdExp(6'h10, 32'h1_0000, "R4");
    wr(6'h10, 32'h0);
    rdExp(6'h08, 32'h0, "R2");
    idle(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule